// File: doc/BRIEF.md
# Programmable Square-Grid QAM Slicer

This block is the decision device placed after a pair of in-phase and quadrature equalizer filters. Each cycle that a sample pair is offered, it picks the nearest point of a square constellation on each axis on its own. It also returns the signed difference between the sample and that point, which the coefficient update logic uses as its error term. Decisions sit at odd multiples of a programmable gain (±1·g, ±3·g, …). The number of levels per axis can be set to 2, 4 or 8.

At start-up the equalizer is not yet converged, so the slicer can run in a blind mode. In that mode only the four innermost points (±g on each axis) are candidates. This makes the decisions equivalent to QPSK decisions. Once the loop has settled, the full programmed grid is selected. The selection comes either from a register bit or from an external convergence flag, chosen by a source-select input. All settings are captured together with the sample, so every result comes from a single consistent setting.

Top module: `qam_slicer`

## Requirements
- R1: `res_valid` is high exactly one clock after a cycle with `smp_valid` high, and low otherwise. The decision and error outputs update on that same edge.
- R2: `lvl_code` selects the levels per axis: 0 gives 2 levels, 1 gives 4 levels, 2 gives 8 levels, and 3 is treated as 8 levels.
- R3: In full mode, each axis decision is the odd multiple of `gain` nearest to the sample. A sample lying exactly halfway between two levels takes the level of larger magnitude. A sample of zero is decided as +g.
- R4: A sample beyond the outermost level saturates to that level, ±(L−1)·g for L levels. This includes the most negative input code.
- R5: Each error output equals the sample minus its decision, in two's complement. It is wide enough to never wrap, and it appears in the same cycle as the decision.
- R6: In blind mode, every decision is +g or −g, whatever `lvl_code` is set to.
- R7: With `src_ext` low, full mode is chosen by `full_reg`. With `src_ext` high, full mode is chosen by `conv_ok`, and `full_reg` is ignored.
- R8: Mode, level and gain inputs act only in cycles with `smp_valid` high. With `smp_valid` low, all outputs hold their values, so no result mixes two constellations.
- R9: The I and Q axes are sliced independently. A decision on one axis does not depend on the sample on the other.
- R10: After reset, `res_valid`, the decisions and the errors are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample pair valid |
| smp_i | input | DW | In-phase sample, signed |
| smp_q | input | DW | Quadrature sample, signed |
| lvl_code | input | LCW | Levels per axis code (R2) |
| gain | input | GW | Level spacing unit g, unsigned |
| full_reg | input | 1 | Register mode bit, 1 = full grid |
| src_ext | input | 1 | 1 = take mode from conv_ok |
| conv_ok | input | 1 | External convergence flag, 1 = full grid |
| res_valid | output | 1 | Result valid |
| dec_i | output | DECW | In-phase decision, signed |
| dec_q | output | DECW | Quadrature decision, signed |
| err_i | output | EW | In-phase error, signed |
| err_q | output | EW | Quadrature error, signed |

## Verification
Every result is due one edge after the sample that produced it: decision, error and valid all pass through the single output register together. The driver queues the expected values when it drives a sample. The monitor compares them on the falling edge after `res_valid` rises, so each check lands half a cycle after the register has loaded. The hold test toggles the mode and level inputs with `smp_valid` low for several cycles. It then reads the outputs at falling edges, where they must be unchanged.

// File: rtl/qam_slicer_pkg.sv
package qam_slicer_pkg;

  // Highest level index reachable for a level code, clipped to the grid size.
  function automatic int unsigned lvl_limit(input int unsigned code,
                                            input int unsigned max_half);
    int unsigned half;
    half = 1 << code;
    if (half > max_half) half = max_half;
    return half - 1;
  endfunction

endpackage

// File: rtl/slicer_ctrl.sv
module slicer_ctrl
  import qam_slicer_pkg::*;
#(
  parameter int MW      = 2,
  parameter int LCW     = 2,
  parameter int MAXHALF = 4
) (
  input  logic [LCW-1:0] lvl_code,
  input  logic           full_reg,
  input  logic           src_ext,
  input  logic           conv_ok,
  output logic           full_en,
  output logic [MW-1:0]  lim
);

  always_comb begin
    full_en = src_ext ? conv_ok : full_reg;
    if (full_en) lim = MW'(lvl_limit(int'(lvl_code), MAXHALF));
    else         lim = '0;
  end

endmodule

// File: rtl/slicer_axis.sv
module slicer_axis #(
  parameter int DW   = 12,
  parameter int GW   = 8,
  parameter int MW   = 2,
  parameter int NTHR = 3,
  parameter int DECW = 12,
  parameter int EW   = 13
) (
  input  logic signed [DW-1:0]   x,
  input  logic        [GW-1:0]   gain,
  input  logic        [MW-1:0]   lim,
  output logic signed [DECW-1:0] dec,
  output logic signed [EW-1:0]   err
);

  localparam int CW  = DW + GW + 2;
  localparam int MDW = GW + MW + 1;

  logic signed [DW:0]  xe;
  logic                neg;
  logic [CW-1:0]       mag_x;
  logic [NTHR-1:0]     hit;
  logic [MW-1:0]       cnt;
  logic [MW-1:0]       sel;
  logic [MDW-1:0]      mag_d;

  assign xe    = DW'(x) == '0 ? '0 : (DW+1)'(x);
  assign neg   = xe < 0;
  assign mag_x = CW'($unsigned(neg ? -xe : xe));

  // Decision thresholds sit at even multiples of the gain.
  for (genvar j = 0; j < NTHR; j++) begin : g_thr
    logic [CW-1:0] thr;
    assign thr    = CW'(gain) * CW'(2 * (j + 1));
    assign hit[j] = mag_x >= thr;
  end

  always_comb begin
    cnt = '0;
    for (int j = 0; j < NTHR; j++) cnt = cnt + MW'(hit[j]);
    sel   = (cnt > lim) ? lim : cnt;
    mag_d = MDW'({sel, 1'b1}) * MDW'(gain);
    dec   = neg ? -$signed({1'b0, mag_d}) : $signed({1'b0, mag_d});
    err   = EW'(x) - EW'(dec);
  end

endmodule

// File: rtl/qam_slicer.sv
module qam_slicer
  import qam_slicer_pkg::*;
#(
  parameter int DW         = 12,
  parameter int GW         = 8,
  parameter int MAX_LEVELS = 8,
  parameter int LCW        = 2,
  localparam int MAXHALF   = MAX_LEVELS / 2,
  localparam int NTHR      = MAXHALF - 1,
  localparam int MW        = (NTHR < 2) ? 1 : $clog2(NTHR + 1),
  localparam int DECW      = GW + MW + 2,
  localparam int EW        = ((DW > DECW) ? DW : DECW) + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   smp_valid,
  input  logic signed [DW-1:0]   smp_i,
  input  logic signed [DW-1:0]   smp_q,
  input  logic [LCW-1:0]         lvl_code,
  input  logic [GW-1:0]          gain,
  input  logic                   full_reg,
  input  logic                   src_ext,
  input  logic                   conv_ok,
  output logic                   res_valid,
  output logic signed [DECW-1:0] dec_i,
  output logic signed [DECW-1:0] dec_q,
  output logic signed [EW-1:0]   err_i,
  output logic signed [EW-1:0]   err_q
);

  logic          full_en;
  logic [MW-1:0] lim;
  logic          full_q;
  logic [GW-1:0] gain_q;

  logic signed [DW-1:0]   smp  [2];
  logic signed [DECW-1:0] dcmb [2];
  logic signed [EW-1:0]   ecmb [2];

  assign smp[0] = smp_i;
  assign smp[1] = smp_q;

  slicer_ctrl #(.MW(MW), .LCW(LCW), .MAXHALF(MAXHALF)) u_ctrl (
    .lvl_code (lvl_code),
    .full_reg (full_reg),
    .src_ext  (src_ext),
    .conv_ok  (conv_ok),
    .full_en  (full_en),
    .lim      (lim)
  );

  for (genvar a = 0; a < 2; a++) begin : g_axis
    slicer_axis #(.DW(DW), .GW(GW), .MW(MW), .NTHR(NTHR),
                  .DECW(DECW), .EW(EW)) u_axis (
      .x    (smp[a]),
      .gain (gain),
      .lim  (lim),
      .dec  (dcmb[a]),
      .err  (ecmb[a])
    );
  end

  // Single output stage; settings are captured only with a sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      dec_i     <= '0;
      dec_q     <= '0;
      err_i     <= '0;
      err_q     <= '0;
      full_q    <= 1'b0;
      gain_q    <= '0;
    end else begin
      res_valid <= smp_valid;
      if (smp_valid) begin
        dec_i  <= dcmb[0];
        dec_q  <= dcmb[1];
        err_i  <= ecmb[0];
        err_q  <= ecmb[1];
        full_q <= full_en;
        gain_q <= gain;
      end
    end
  end

  logic signed [DECW-1:0] gain_s;
  assign gain_s = $signed(DECW'(gain_q));

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> res_valid) else $error("valid latency"); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> (!res_valid && $stable(dec_i) && $stable(dec_q) &&
                    $stable(err_i) && $stable(err_q))) else $error("hold"); // R8

  AST_ERR_SUM: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (err_i == EW'($past(smp_i)) - EW'(dec_i)) &&
                  (err_q == EW'($past(smp_q)) - EW'(dec_q))) else $error("err"); // R5

  AST_BLIND_INNER: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !full_q) |-> ((dec_i == gain_s || dec_i == -gain_s) &&
                                (dec_q == gain_s || dec_q == -gain_s))) else $error("blind"); // R6

endmodule

// File: tb/qam_slicer_test.sv
module qam_slicer_test;

  localparam int DW = 12, GW = 8, DECW = 12, EW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0] smp_i = '0, smp_q = '0;
  logic [1:0] lvl_code = '0;
  logic [GW-1:0] gain = '0;
  logic full_reg = 1'b0, src_ext = 1'b0, conv_ok = 1'b0;
  logic res_valid;
  logic signed [DECW-1:0] dec_i, dec_q;
  logic signed [EW-1:0] err_i, err_q;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { int di; int dq; int ei; int eq; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  qam_slicer uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
    .lvl_code(lvl_code), .gain(gain), .full_reg(full_reg), .src_ext(src_ext),
    .conv_ok(conv_ok), .res_valid(res_valid), .dec_i(dec_i), .dec_q(dec_q),
    .err_i(err_i), .err_q(err_q)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int model(input int x, input int code, input int g, input bit full);
    int a, m, lim, mag;
    a = (x < 0) ? -x : x;
    m = 0;
    for (int j = 1; j <= 3; j++) if (a >= 2 * j * g) m = j;
    lim = full ? ((code >= 2) ? 3 : ((1 << code) - 1)) : 0;
    if (m > lim) m = lim;
    mag = (2 * m + 1) * g;
    return (x < 0) ? -mag : mag;
  endfunction

  task automatic send(input int xi, input int xq, input int code, input int g,
                      input bit freg, input bit sext, input bit cok, input string tag);
    exp_t e;
    bit full;
    @(negedge clk);
    smp_valid = 1'b1; smp_i = DW'(xi); smp_q = DW'(xq);
    lvl_code = 2'(code); gain = GW'(g);
    full_reg = freg; src_ext = sext; conv_ok = cok;
    full = sext ? cok : freg;
    e.di = model(xi, code, g, full);
    e.dq = model(xq, code, g, full);
    e.ei = xi - e.di;
    e.eq = xq - e.dq;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: results are due one edge after the sample, read at the falling edge.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (sb.size() == 0) check("R1 unexpected valid", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " dec_i"}, int'(dec_i), e.di);
        check({e.tag, " dec_q"}, int'(dec_q), e.dq);
        check({e.tag, " err_i"}, int'(err_i), e.ei);
        check({e.tag, " err_q"}, int'(err_q), e.eq);
      end
    end
  end

  initial begin
    int hd_i, hd_q, he_i, he_q;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R10 valid", int'(res_valid), 0);
    check("R10 dec_i", int'(dec_i), 0);
    check("R10 err_q", int'(err_q), 0);

    // R3 nearest level, ties outward, zero positive; R9 independent axes
    send(0, 31, 2, 16, 1, 0, 0, "R3 zero/near");
    send(32, -33, 2, 16, 1, 0, 0, "R3 tie");
    send(-31, 95, 2, 16, 1, 0, 0, "R9 axes");
    // R4 saturation, including most negative code
    send(200, -2048, 2, 16, 1, 0, 0, "R4 sat");
    send(2047, -97, 3, 16, 1, 0, 0, "R4 code3");
    // R2 level codes
    send(100, -100, 1, 16, 1, 0, 0, "R2 four");
    send(100, -100, 0, 16, 1, 0, 0, "R2 two");
    send(63, -64, 1, 16, 1, 0, 0, "R2 four edge");
    // R6 blind forces inner points
    send(1000, -1000, 2, 40, 0, 0, 0, "R6 blind");
    // R7 external source
    send(300, -300, 2, 40, 0, 1, 1, "R7 ext full");
    send(300, -300, 2, 40, 1, 1, 0, "R7 ext blind");
    // R5 error range with large gain
    send(-2048, 2047, 2, 255, 1, 0, 0, "R5 err");
    // back-to-back sweep, R1 latency under continuous valid
    for (int k = 0; k < 40; k++) begin
      int xi, xq, c, g;
      xi = int'($urandom_range(4095)) - 2048;
      xq = int'($urandom_range(4095)) - 2048;
      c = int'($urandom_range(3));
      g = int'($urandom_range(255));
      send(xi, xq, c, g, k[0], k[1], k[2], "R1 sweep");
    end
    @(negedge clk) smp_valid = 1'b0;
    @(negedge clk);
    check("R1 queue drained", sb.size(), 0);

    // R8: change settings with no sample; outputs must hold
    hd_i = int'(dec_i); hd_q = int'(dec_q); he_i = int'(err_i); he_q = int'(err_q);
    full_reg = ~full_reg; src_ext = 1'b0; lvl_code = 2'd0; gain = 8'd3;
    smp_i = 12'sd500; smp_q = -12'sd500;
    repeat (3) @(negedge clk);
    check("R8 valid low", int'(res_valid), 0);
    check("R8 dec_i hold", int'(dec_i), hd_i);
    check("R8 dec_q hold", int'(dec_q), hd_q);
    check("R8 err_i hold", int'(err_i), he_i);
    check("R8 err_q hold", int'(err_q), he_q);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule